// File: doc/BRIEF.md
# Dual-Rail Phase-Encoded Link Codec with Void Tokens

This block is the transmit and receive pair of one router link in a time-division-multiplexed network. Each bit crosses the link as two wires: a value wire and a parity wire. A token is signalled by a phase change on the pairs. The transmitter keeps the parity equal to the value XOR the current phase, so each token flips exactly one wire in every pair it advances. The receiver sees a token when value XOR parity reaches the phase it expects next.

Every time slot carries a token, whether or not there is a phit to send. A phit token carries a valid header or data phit. A void token carries nothing and only keeps the slots moving. For a void token, only the pair for the valid bit advances. The 33 header-flag and payload pairs keep their wires still, which saves switching. The valid-bit pair and the payload pairs therefore reach different phases, and both ends track the two phases separately.

The receiver reads the valid-bit pair first to learn the token kind. For a phit token it then waits until every payload pair has completed before it latches the phit. The decoded output is a 34-bit phit with a one-cycle strobe for each token. The delays of a real link are modelled synchronously: the bench can hold the payload wires back by one cycle.

Top module: `dr_link_codec`

## Requirements
- R1: While reset is low and after it is released, all link wires are 0, `rx_tok` is 0 and `rx_phit` is 0. The type phase and the data phase both start at 0.
- R2: On every pair, each token that advances it flips exactly one of its two wires. After the flip, value XOR parity equals the new phase of that pair's group.
- R3: A phit token (`tx_phit[33]`=1) toggles the type phase and the data phase. The valid pair takes value 1. Data pair i takes value `tx_phit[i]`, where bit 32 is the header flag and bits 31:0 are the payload. The new wire values appear on the clock edge that samples `tx_send`.
- R4: A void token (`tx_phit[33]`=0) toggles only the type phase and sets the valid pair's value to 0. All 66 data wires stay unchanged.
- R5: In a cycle without `tx_send`, no link wire changes.
- R6: For each token, `rx_tok` is high for exactly one cycle. It is registered on the clock edge at which all the wires the token needs show the new phase.
- R7: A phit token is decoded as `rx_phit` = {1, header flag, payload}, equal to the sent phit.
- R8: A void token is decoded with `rx_phit[33]`=0 and `rx_phit[32:0]` keeping the last phit's header flag and payload.
- R9: If the valid pair of a phit token arrives before its data pairs, the receiver does not emit the token until all 33 data pairs show the new data phase.
- R10: Any mix of phit and void tokens, including long runs of void tokens, decodes correctly. This requires the receiver's type phase to toggle on every token and its data phase to toggle only on phit tokens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ends |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_send | input | 1 | Send one token this cycle |
| tx_phit | input | 34 | Token to send: bit 33 valid (token kind), bit 32 header flag, bits 31:0 payload |
| tx_type_val | output | 1 | Value wire of the valid-bit pair |
| tx_type_par | output | 1 | Parity wire of the valid-bit pair |
| tx_data_val | output | 33 | Value wires of the header-flag and payload pairs |
| tx_data_par | output | 33 | Parity wires of the header-flag and payload pairs |
| rx_type_val | input | 1 | Received value wire of the valid-bit pair |
| rx_type_par | input | 1 | Received parity wire of the valid-bit pair |
| rx_data_val | input | 33 | Received value wires of the data pairs |
| rx_data_par | input | 33 | Received parity wires of the data pairs |
| rx_tok | output | 1 | One-cycle strobe for each decoded token |
| rx_phit | output | 34 | Decoded phit, same field layout as `tx_phit` |

## Verification
The bound checker checks the transmitter on every cycle:
- each token flips exactly one wire per advanced pair;
- void tokens leave the data wires still;
- idle cycles change nothing;
- a void output keeps the last payload.

Whether decoded phits equal the sent ones after long mixed runs depends on end-to-end phase tracking. So does the extra cycle of delay when the data pairs lag the valid pair. Only the bench's scenarios show these, using random 70/30 phit/void streams and directed cases with skewed data wires.

// File: rtl/dr_link_pkg.sv
// Shared types for the dual-rail link codec.
package dr_link_pkg;

    // Receiver control state: idle, or holding a phit token whose data pairs are late
    typedef enum logic {
        RX_IDLE = 1'b0,
        RX_WAIT = 1'b1
    } rx_state_e;

endpackage

// File: rtl/dr_pair_enc.sv
// One value/parity wire pair driver.
// What it does: on load, puts the bit on the value wire and bit XOR phase on the
// parity wire, so the pair then decodes to the given phase.
// Assumes: the caller passes the phase that follows the current one, so one wire flips.
module dr_pair_enc (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic bit_in,
    input  logic phase_in,
    output logic val_q,
    output logic par_q
);

    // Register the pair; it holds its wires whenever there is no load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_q <= 1'b0;
            par_q <= 1'b0;
        end else if (load) begin
            val_q <= bit_in;
            par_q <= bit_in ^ phase_in;
        end
    end

endmodule

// File: rtl/dr_tx.sv
// Link transmitter.
// What it does: the type phase toggles on every token and the data phase only on
// phit tokens. The valid-bit pair is driven on every token and the 33 data pairs
// only on phit tokens.
// Assumes: at most one token per cycle; the link side paces the tokens.
module dr_tx #(
    parameter int GRP_W = 33
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             send,
    input  logic [GRP_W:0]   phit,
    output logic             type_val,
    output logic             type_par,
    output logic [GRP_W-1:0] data_val,
    output logic [GRP_W-1:0] data_par
);

    logic tphase_q;
    logic dphase_q;
    logic is_phit;
    logic data_load;

    assign is_phit   = phit[GRP_W];
    assign data_load = send & is_phit;

    // Phase toggles: type phase on every token, data phase on phit tokens only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tphase_q <= 1'b0;
            dphase_q <= 1'b0;
        end else begin
            if (send)      tphase_q <= ~tphase_q;
            if (data_load) dphase_q <= ~dphase_q;
        end
    end

    dr_pair_enc u_type (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (send),
        .bit_in   (is_phit),
        .phase_in (~tphase_q),
        .val_q    (type_val),
        .par_q    (type_par)
    );

    for (genvar gi = 0; gi < GRP_W; gi++) begin : g_data_pair
        dr_pair_enc u_pair (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (data_load),
            .bit_in   (phit[gi]),
            .phase_in (~dphase_q),
            .val_q    (data_val[gi]),
            .par_q    (data_par[gi])
        );
    end

endmodule

// File: rtl/dr_group_detect.sv
// Completion detector for a group of pairs.
// What it does: reports when every pair in the group decodes (value XOR parity)
// to the wanted phase.
// Assumes: purely combinational; the pairs flip monotonically toward the new phase.
module dr_group_detect #(
    parameter int W = 33
) (
    input  logic [W-1:0] pair_val,
    input  logic [W-1:0] pair_par,
    input  logic         want_phase,
    output logic         all_match
);

    logic [W-1:0] hit;

    for (genvar gi = 0; gi < W; gi++) begin : g_hit
        assign hit[gi] = (pair_val[gi] ^ pair_par[gi]) == want_phase;
    end

    // Reduce the per-pair matches into one completion flag
    always_comb begin
        all_match = &hit;
    end

endmodule

// File: rtl/dr_rx.sv
// Link receiver.
// What it does: sees a token when the valid-bit pair reaches the next type phase;
// the valid bit gives the kind. A void token is emitted at once. A phit token
// waits until all data pairs reach the next data phase, then is latched and emitted.
// Assumes: the next token does not start before the current one has completed.
module dr_rx
    import dr_link_pkg::*;
#(
    parameter int GRP_W = 33
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_type_val,
    input  logic             in_type_par,
    input  logic [GRP_W-1:0] in_data_val,
    input  logic [GRP_W-1:0] in_data_par,
    output logic             out_tok,
    output logic [GRP_W:0]   out_phit
);

    rx_state_e        state_q;
    logic             exp_t_q;
    logic             exp_d_q;
    logic             kind_q;
    logic [GRP_W-1:0] data_q;
    logic             type_arr;
    logic             data_done;
    logic             take_type;
    logic             take_data;

    dr_group_detect #(.W(1)) u_type_det (
        .pair_val   (in_type_val),
        .pair_par   (in_type_par),
        .want_phase (~exp_t_q),
        .all_match  (type_arr)
    );

    dr_group_detect #(.W(GRP_W)) u_data_det (
        .pair_val   (in_data_val),
        .pair_par   (in_data_par),
        .want_phase (~exp_d_q),
        .all_match  (data_done)
    );

    // Decide which group is consumed this cycle
    always_comb begin
        take_type = (state_q == RX_IDLE) && type_arr;
        take_data = data_done && ((state_q == RX_WAIT) || (take_type && in_type_val));
    end

    // Phase tracking, wait state and output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
            exp_t_q <= 1'b0;
            exp_d_q <= 1'b0;
            kind_q  <= 1'b0;
            data_q  <= '0;
            out_tok <= 1'b0;
        end else begin
            out_tok <= (take_type && !in_type_val) || take_data;
            if (take_type) exp_t_q <= ~exp_t_q;
            if (take_data) begin
                exp_d_q <= ~exp_d_q;
                data_q  <= in_data_val;
                kind_q  <= 1'b1;
            end else if (take_type && !in_type_val) begin
                kind_q  <= 1'b0;
            end
            if (take_type && in_type_val && !data_done) state_q <= RX_WAIT;
            else if (state_q == RX_WAIT && data_done)   state_q <= RX_IDLE;
        end
    end

    assign out_phit = {kind_q, data_q};

endmodule

// File: rtl/dr_link_codec.sv
// Dual-rail phase-encoded link codec: the transmitter and the receiver of one link.
// What it does: encodes phit and void tokens onto value/parity pairs and decodes
// received pairs back into phits with a one-cycle strobe.
// Assumes: the link wires between the two ends are external, so any delay
// or skew is modelled outside this module.
module dr_link_codec #(
    parameter int PAYLOAD_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tx_send,
    input  logic [PAYLOAD_W+1:0] tx_phit,
    output logic                 tx_type_val,
    output logic                 tx_type_par,
    output logic [PAYLOAD_W:0]   tx_data_val,
    output logic [PAYLOAD_W:0]   tx_data_par,
    input  logic                 rx_type_val,
    input  logic                 rx_type_par,
    input  logic [PAYLOAD_W:0]   rx_data_val,
    input  logic [PAYLOAD_W:0]   rx_data_par,
    output logic                 rx_tok,
    output logic [PAYLOAD_W+1:0] rx_phit
);

    localparam int GRP_W = PAYLOAD_W + 1;

    dr_tx #(.GRP_W(GRP_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .send     (tx_send),
        .phit     (tx_phit),
        .type_val (tx_type_val),
        .type_par (tx_type_par),
        .data_val (tx_data_val),
        .data_par (tx_data_par)
    );

    dr_rx #(.GRP_W(GRP_W)) u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_type_val (rx_type_val),
        .in_type_par (rx_type_par),
        .in_data_val (rx_data_val),
        .in_data_par (rx_data_par),
        .out_tok     (rx_tok),
        .out_phit    (rx_phit)
    );

endmodule

// File: rtl/dr_link_codec_chk.sv
// Assertion checker for dr_link_codec, attached by bind.
// What it does: watches the transmitter wires and the receiver output.
// Assumes: ports are sampled on the codec clock.
module dr_link_codec_chk #(
    parameter int PAYLOAD_W = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 tx_send,
    input logic [PAYLOAD_W+1:0] tx_phit,
    input logic                 tx_type_val,
    input logic                 tx_type_par,
    input logic [PAYLOAD_W:0]   tx_data_val,
    input logic [PAYLOAD_W:0]   tx_data_par,
    input logic                 rx_tok,
    input logic [PAYLOAD_W+1:0] rx_phit
);

    localparam int GRP_W = PAYLOAD_W + 1;

    // R2: a token flips exactly one wire of the valid-bit pair
    assert_type_one_flip_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_send |=> ((tx_type_val != $past(tx_type_val)) != (tx_type_par != $past(tx_type_par))));

    // R3: a phit token flips exactly one wire in every data pair
    assert_data_one_flip_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_send && tx_phit[GRP_W]) |=>
            (((tx_data_val ^ $past(tx_data_val)) ^ (tx_data_par ^ $past(tx_data_par))) == {GRP_W{1'b1}}));

    // R4: a void token leaves every data wire still
    assert_void_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_send && !tx_phit[GRP_W]) |=> ($stable(tx_data_val) && $stable(tx_data_par)));

    // R5: no wire moves without a token
    assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_send |=> ($stable(tx_type_val) && $stable(tx_type_par)
                      && $stable(tx_data_val) && $stable(tx_data_par)));

    // R8: a decoded void token keeps the last header flag and payload
    assert_void_holds_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_tok && !rx_phit[GRP_W]) |-> (rx_phit[GRP_W-1:0] == $past(rx_phit[GRP_W-1:0])));

endmodule

bind dr_link_codec dr_link_codec_chk #(.PAYLOAD_W(PAYLOAD_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_send     (tx_send),
    .tx_phit     (tx_phit),
    .tx_type_val (tx_type_val),
    .tx_type_par (tx_type_par),
    .tx_data_val (tx_data_val),
    .tx_data_par (tx_data_par),
    .rx_tok      (rx_tok),
    .rx_phit     (rx_phit)
);

// File: tb/dr_link_codec_test.sv
`timescale 1ns/1ps
module dr_link_codec_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_send = 1'b0;
    logic [33:0] tx_phit = '0;
    logic        tx_tv, tx_tp;
    logic [32:0] tx_dv, tx_dp;
    logic [32:0] dly_dv = '0, dly_dp = '0;
    logic [32:0] rx_dv, rx_dp;
    logic        skew = 1'b0;
    logic        rx_tok;
    logic [33:0] rx_phit;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // bench model state
    logic        m_tph = 0, m_dph = 0;
    logic        m_tv = 0, m_tp = 0;
    logic [32:0] m_dv = '0, m_dp = '0;
    logic [32:0] m_last = '0;

    always #2 clk = ~clk;

    // link model: payload wires optionally lag by one cycle
    always @(posedge clk) begin
        dly_dv <= tx_dv;
        dly_dp <= tx_dp;
    end
    assign rx_dv = skew ? dly_dv : tx_dv;
    assign rx_dp = skew ? dly_dp : tx_dp;

    dr_link_codec uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_send     (tx_send),
        .tx_phit     (tx_phit),
        .tx_type_val (tx_tv),
        .tx_type_par (tx_tp),
        .tx_data_val (tx_dv),
        .tx_data_par (tx_dp),
        .rx_type_val (tx_tv),
        .rx_type_par (tx_tp),
        .rx_data_val (rx_dv),
        .rx_data_par (rx_dp),
        .rx_tok      (rx_tok),
        .rx_phit     (rx_phit)
    );

    task automatic chk(input string tag, input logic [67:0] act, input logic [67:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [67:0] wires_exp();
        return {m_dv, m_dp, m_tv, m_tp};
    endfunction

    function automatic logic [33:0] out_exp(input logic [33:0] p);
        return p[33] ? p : {1'b0, m_last};
    endfunction

    // one token with all follow-up checks; the link is quiet again at the end
    task automatic send_token(input logic [33:0] p);
        logic [33:0] want;
        @(negedge clk);
        tx_send = 1'b1;
        tx_phit = p;
        m_tph = ~m_tph;
        m_tv  = p[33];
        m_tp  = p[33] ^ m_tph;
        if (p[33]) begin
            m_dph = ~m_dph;
            m_dv  = p[32:0];
            m_dp  = p[32:0] ^ {33{m_dph}};
        end
        want = out_exp(p);
        if (p[33]) m_last = p[32:0];
        @(negedge clk);
        tx_send = 1'b0;
        chk(p[33] ? "R3 R2 phit wires" : "R4 R2 void wires", {tx_dv, tx_dp, tx_tv, tx_tp}, wires_exp());
        if (skew && p[33]) begin
            @(negedge clk);
            chk("R9 no strobe before data complete", {67'b0, rx_tok}, 68'd1 - 68'd1);
        end
        @(negedge clk);
        chk("R6 strobe", {67'b0, rx_tok}, 68'd1);
        chk(p[33] ? "R7 phit decoded" : "R8 void decoded", {34'b0, rx_phit}, {34'b0, want});
        @(negedge clk);
        chk("R6 single-cycle strobe", {67'b0, rx_tok}, 68'd0);
        chk("R5 idle wires still", {tx_dv, tx_dp, tx_tv, tx_tp}, wires_exp());
    endtask

    function automatic logic [33:0] rnd_token();
        logic [33:0] p;
        p[31:0] = $urandom;
        p[32]   = $urandom_range(0, 3) == 0;
        p[33]   = $urandom_range(0, 9) < 7;
        return p;
    endfunction

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1C0DE5));
        repeat (3) @(negedge clk);
        chk("R1 reset wires", {tx_dv, tx_dp, tx_tv, tx_tp}, 68'd0);
        chk("R1 reset outputs", {33'b0, rx_tok, rx_phit}, 68'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", {33'b0, rx_tok, rx_phit}, 68'd0);

        // directed: void first, so the held data is the reset value (R8)
        send_token({1'b0, 1'b1, 32'hFFFF_FFFF});
        send_token({1'b1, 1'b1, 32'hDEAD_BEEF});
        send_token({1'b1, 1'b0, 32'h0000_0000});
        send_token({1'b1, 1'b0, 32'h0000_0000});
        // R10: long void run then a phit whose data phase lags by many tokens
        for (int i = 0; i < 7; i++) send_token({1'b0, 33'h1_2345_6789});
        send_token({1'b1, 1'b1, 32'hFFFF_FFFF});
        // R9: skewed payload wires
        skew = 1'b1;
        send_token({1'b1, 1'b0, 32'hA5A5_5A5A});
        send_token({1'b0, 33'h0});
        send_token({1'b1, 1'b1, 32'h0F0F_F0F0});
        skew = 1'b0;

        // random 70/30 phit/void stream, skew chosen per token (R10)
        for (int i = 0; i < 400; i++) begin
            skew = $urandom_range(0, 3) == 0;
            send_token(rnd_token());
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule